// File: doc/BRIEF.md
# Legacy INTx Message Router

This block sits between downstream PCIe ports and the interrupt fabric. Each downstream port sends in-band messages that raise or drop one of four virtual level interrupt lines (pins A to D, coded 0 to 3). The block records the level that every source holds on every pin. It takes the OR across sources to form one level per pin. It then routes that level to one of three outcomes: an MSI write request, a forwarded assert or deassert message towards the legacy interrupt hub upstream (the boot-interrupt path), or nothing at all.

The routing of a pin depends on three inputs. The first is a mask bit for that pin in the redirection control. The second is a boot-interrupt disable bit, which is active high: 0 keeps forwarding enabled and 1 turns it off. The third is a separate route-disable bit, which blocks upstream forwarding on its own. MSI requests leave through a valid/ready handshake and are queued per pin while the consumer stalls. Upstream messages leave one per cycle, and a message is sent only when the level the upstream hub sees for a pin has to change.

Top module: `intx_msg_router`

## Requirements
- R1: After reset, every source level is clear, and neither `msi_valid` nor `up_valid` is high.
- R2: An unmasked pin (its `cfg_pin_mask` bit is 0) whose level goes from 0 to 1 produces exactly one MSI request, and `msi_pin` carries the pin code (0=A, 1=B, 2=C, 3=D).
- R3: The level of a pin is the OR of its per-source states (`msg_assert` 1 = assert, 0 = deassert). A second assert from any source, or a deassert from one source while another source still holds the pin, produces no MSI request and no upstream message.
- R4: A masked pin (mask bit 1) sends an upstream message with `up_assert`=1 when its level rises and `up_assert`=0 when it falls, provided both `cfg_boot_dis` and `cfg_route_dis` are 0. A masked pin never produces an MSI request.
- R5: While `cfg_boot_dis` is 1, a masked pin raises nothing upstream. An unmasked pin still produces MSI requests.
- R6: While `cfg_route_dis` is 1, a masked pin causes no action. An unmasked pin still produces MSI requests.
- R7: If the mask, boot-disable or route-disable setting changes while a pin is high, any assert already forwarded upstream for that pin is withdrawn with a deassert. The pin is then routed again at its current level: it is forwarded again if forwarding now applies, and it produces an MSI request if it has just become unmasked.
- R8: When several pins need an upstream message in the same cycle, one message leaves per cycle, lowest pin code first.
- R9: While `msi_valid` is high and `msi_ready` is low, `msi_valid` and `msi_pin` hold steady. Each pin queues up to 2^CNT_W-1 requests behind the one being presented, and further requests for that pin are dropped. Queued requests are granted lowest pin code first.
- R10: A message whose `msg_src` is NUM_SRC or above changes no state and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | An INTx message is present this cycle |
| msg_assert | input | 1 | 1 = assert message, 0 = deassert message |
| msg_pin | input | 2 | Virtual pin code, 0=A to 3=D |
| msg_src | input | SRC_W | Index of the downstream source port |
| cfg_pin_mask | input | 4 | Per-pin redirection mask, 1 = masked (fall back to forwarding) |
| cfg_boot_dis | input | 1 | Boot-interrupt disable, 1 = forwarding off |
| cfg_route_dis | input | 1 | Route-disable, 1 = never forward upstream |
| msi_valid | output | 1 | MSI request presented |
| msi_ready | input | 1 | Consumer accepts the MSI request |
| msi_pin | output | 2 | Pin whose MSI is requested |
| up_valid | output | 1 | Upstream message presented this cycle |
| up_assert | output | 1 | 1 = upstream assert, 0 = upstream deassert |
| up_pin | output | 2 | Pin of the upstream message |

## Verification
The bench drives four kinds of input pattern. Single-source pulses on an unmasked pin and on a masked pin separate the MSI outcome from the forwarding outcome. Overlapping asserts from several sources on one pin show whether the per-source OR suppresses extra requests and messages. Control changes applied while pins are held high show whether a forwarded assert is withdrawn and the pin is routed again, and releasing a disable over three held pins shows the order in which upstream messages leave. Bursts of pulses against a stalled MSI consumer show whether requests are held, queued per pin, saturated and then granted in pin order.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
   localparam int PIN_CNT = 4;
   localparam int PIN_W   = 2;

   typedef logic [PIN_W-1:0]   pin_idx_t;
   typedef logic [PIN_CNT-1:0] pin_vec_t;

   // lowest set bit of a pin vector (0 when empty)
   function automatic pin_idx_t lowest_pin(input pin_vec_t v);
      pin_idx_t r;
      r = '0;
      for (int i = PIN_CNT - 1; i >= 0; i--) begin
         if (v[i]) r = pin_idx_t'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/intx_level_track.sv
module intx_level_track
   import intx_router_pkg::*;
#(
   parameter int NUM_SRC = 3,
   parameter int SRC_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic             msg_assert,
   input  pin_idx_t         msg_pin,
   input  logic [SRC_W-1:0] msg_src,
   output pin_vec_t         pin_level
);
   logic src_ok;

   // source range check: a full power-of-two range needs no compare
   generate
      if (NUM_SRC == (1 << SRC_W)) begin : g_full_range
         assign src_ok = 1'b1;
      end else begin : g_part_range
         assign src_ok = (msg_src < SRC_W'(NUM_SRC));
      end
   endgenerate

   logic upd;
   assign upd = msg_valid && src_ok;

   generate
      for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
         logic [NUM_SRC-1:0] held;
         for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            logic hit;
            assign hit = upd && (msg_pin == pin_idx_t'(p)) && (msg_src == SRC_W'(s));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   held[s] <= 1'b0;
               else if (hit) held[s] <= msg_assert;
            end
         end
         assign pin_level[p] = |held;
      end
   endgenerate
endmodule

// File: rtl/intx_up_sender.sv
module intx_up_sender
   import intx_router_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pin_vec_t route_up,
   output logic     up_valid,
   output logic     up_assert,
   output pin_idx_t up_pin
);
   pin_vec_t sent;
   pin_vec_t diff;

   // mirror of what the upstream hub believes; send only differences
   assign diff      = route_up ^ sent;
   assign up_valid  = |diff;
   assign up_pin    = lowest_pin(diff);
   assign up_assert = route_up[up_pin];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sent <= '0;
      else if (up_valid) sent[up_pin] <= up_assert;
   end
endmodule

// File: rtl/intx_msi_queue.sv
module intx_msi_queue
   import intx_router_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_vec_t msi_level,
   input  logic     msi_ready,
   output logic     msi_valid,
   output pin_idx_t msi_pin
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   pin_vec_t prev;
   pin_vec_t rise;
   pin_vec_t nz;
   pin_vec_t take;
   logic     load;
   pin_idx_t pick;

   assign rise = msi_level & ~prev;
   assign load = !msi_valid || msi_ready;
   assign pick = lowest_pin(nz);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= msi_level;
   end

   generate
      for (genvar p = 0; p < PIN_CNT; p++) begin : g_cnt
         logic [CNT_W-1:0] cnt;
         assign nz[p]   = (cnt != '0);
         assign take[p] = load && (pick == pin_idx_t'(p)) && nz[p];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else begin
               unique case ({rise[p], take[p]})
                  2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end
      end
   endgenerate

   // output holding stage keeps the request stable under back-pressure
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msi_valid <= 1'b0;
         msi_pin   <= '0;
      end else if (load) begin
         msi_valid <= |nz;
         if (|nz) msi_pin <= pick;
      end
   end
endmodule

// File: rtl/intx_msg_router.sv
module intx_msg_router
   import intx_router_pkg::*;
#(
   parameter  int NUM_SRC = 3,
   parameter  int CNT_W   = 2,
   localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic             msg_assert,
   input  logic [1:0]       msg_pin,
   input  logic [SRC_W-1:0] msg_src,
   input  logic [3:0]       cfg_pin_mask,
   input  logic             cfg_boot_dis,
   input  logic             cfg_route_dis,
   output logic             msi_valid,
   input  logic             msi_ready,
   output logic [1:0]       msi_pin,
   output logic             up_valid,
   output logic             up_assert,
   output logic [1:0]       up_pin
);
   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   pin_vec_t pin_level;
   pin_vec_t msi_level;
   pin_vec_t route_up;
   logic     fwd_ok;

   intx_level_track #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .msg_valid  (msg_valid),
      .msg_assert (msg_assert),
      .msg_pin    (msg_pin),
      .msg_src    (msg_src),
      .pin_level  (pin_level)
   );

   assign fwd_ok    = !cfg_boot_dis && !cfg_route_dis;
   assign msi_level = pin_level & ~cfg_pin_mask;
   assign route_up  = pin_level & cfg_pin_mask & {PIN_CNT{fwd_ok}};

   intx_up_sender u_up (
      .clk       (clk),
      .rst_n     (rst_n),
      .route_up  (route_up),
      .up_valid  (up_valid),
      .up_assert (up_assert),
      .up_pin    (up_pin)
   );

   intx_msi_queue #(.CNT_W(CNT_W)) u_msi (
      .clk       (clk),
      .rst_n     (rst_n),
      .msi_level (msi_level),
      .msi_ready (msi_ready),
      .msi_valid (msi_valid),
      .msi_pin   (msi_pin)
   );
endmodule

// File: rtl/intx_router_checker.sv
module intx_router_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] cfg_pin_mask,
   input logic       cfg_boot_dis,
   input logic       cfg_route_dis,
   input logic       msi_valid,
   input logic       msi_ready,
   input logic [1:0] msi_pin,
   input logic       up_valid,
   input logic       up_assert,
   input logic [1:0] up_pin
);
   // what the upstream hub has been told, rebuilt from the port stream
   logic [3:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen <= '0;
      else if (up_valid) seen[up_pin] <= up_assert;
   end

   p_no_dup_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (up_assert != seen[up_pin]));

   p_masked_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_assert) |-> cfg_pin_mask[up_pin]);

   p_boot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && cfg_boot_dis) |-> !up_assert);

   p_route_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && cfg_route_dis) |-> !up_assert);

   p_msi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_pin)));
endmodule

bind intx_msg_router intx_router_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_pin_mask  (cfg_pin_mask),
   .cfg_boot_dis  (cfg_boot_dis),
   .cfg_route_dis (cfg_route_dis),
   .msi_valid     (msi_valid),
   .msi_ready     (msi_ready),
   .msi_pin       (msi_pin),
   .up_valid      (up_valid),
   .up_assert     (up_assert),
   .up_pin        (up_pin)
);

// File: tb/tb_intx_msg_router.sv
module tb_intx_msg_router;
   localparam int NSRC = 3;
   localparam int CMAX = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_valid = 1'b0, msg_assert = 1'b0;
   logic [1:0] msg_pin = '0;
   logic [1:0] msg_src = '0;
   logic [3:0] cfg_pin_mask = '0;
   logic       cfg_boot_dis = 1'b0, cfg_route_dis = 1'b0;
   logic       msi_ready = 1'b1;
   logic       msi_valid, up_valid, up_assert;
   logic [1:0] msi_pin, up_pin;

   always #4 clk = ~clk;

   intx_msg_router #(.NUM_SRC(NSRC), .CNT_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_assert(msg_assert),
      .msg_pin(msg_pin), .msg_src(msg_src), .cfg_pin_mask(cfg_pin_mask),
      .cfg_boot_dis(cfg_boot_dis), .cfg_route_dis(cfg_route_dis),
      .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_pin(msi_pin),
      .up_valid(up_valid), .up_assert(up_assert), .up_pin(up_pin));

   int    total = 0, bad = 0;
   string phase = "R1";

   // behavioural reference state
   bit m_src [4][NSRC];
   bit m_sent [4];
   bit m_prev [4];
   int m_cnt [4];
   bit m_ov;
   int m_op;

   // event logs taken at the ports
   int msi_log [64];
   int up_log  [64];
   int msi_n = 0, up_n = 0;

   function automatic bit lvl(int p);
      bit r = 0;
      for (int s = 0; s < NSRC; s++) r |= m_src[p][s];
      return r;
   endfunction

   function automatic bit des(int p);
      return lvl(p) && cfg_pin_mask[p] && !cfg_boot_dis && !cfg_route_dis;
   endfunction

   function automatic int up_pick();
      for (int p = 0; p < 4; p++) if (des(p) != m_sent[p]) return p;
      return -1;
   endfunction

   always @(posedge clk) begin
      int pk, q;
      bit rise [4];
      bit dec [4];
      if (!rst_n) begin
         for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < NSRC; s++) m_src[p][s] = 0;
            m_sent[p] = 0; m_prev[p] = 0; m_cnt[p] = 0;
         end
         m_ov = 0; m_op = 0;
      end else begin
         pk = up_pick();
         for (int p = 0; p < 4; p++) begin
            rise[p] = lvl(p) && !cfg_pin_mask[p] && !m_prev[p];
            m_prev[p] = lvl(p) && !cfg_pin_mask[p];
            dec[p] = 0;
         end
         if (pk >= 0) m_sent[pk] = des(pk);
         if (!m_ov || msi_ready) begin
            q = -1;
            for (int p = 3; p >= 0; p--) if (m_cnt[p] > 0) q = p;
            if (q >= 0) begin m_ov = 1; m_op = q; dec[q] = 1; end
            else m_ov = 0;
         end
         for (int p = 0; p < 4; p++) begin
            if (rise[p] && !dec[p]) begin
               if (m_cnt[p] < CMAX) m_cnt[p]++;
            end else if (!rise[p] && dec[p]) m_cnt[p]--;
         end
         if (msg_valid && int'(msg_src) < NSRC)
            m_src[msg_pin][msg_src] = msg_assert;
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      int pk;
      bit ev, ea;
      int ep;
      if (rst_n) begin
         pk = up_pick();
         ev = (pk >= 0);
         ea = ev ? des(pk) : 1'b0;
         ep = ev ? pk : 0;
         total++;
         if (up_valid !== ev || (ev && (up_assert !== ea || int'(up_pin) != ep))) begin
            bad++;
            $display("FAIL %s upstream: got v=%0b a=%0b p=%0d exp v=%0b a=%0b p=%0d",
                     phase, up_valid, up_assert, up_pin, ev, ea, ep);
         end
         total++;
         if (msi_valid !== m_ov || (m_ov && int'(msi_pin) != m_op)) begin
            bad++;
            $display("FAIL %s msi: got v=%0b p=%0d exp v=%0b p=%0d",
                     phase, msi_valid, msi_pin, m_ov, m_op);
         end
         if (msi_valid && msi_ready && msi_n < 64) begin msi_log[msi_n] = msi_pin; msi_n++; end
         if (up_valid && up_n < 64) begin up_log[up_n] = {up_assert, up_pin}; up_n++; end
      end
   end

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(int pin, int src, bit a);
      @(posedge clk); #1;
      msg_valid = 1; msg_pin = 2'(pin); msg_src = 2'(src); msg_assert = a;
      @(posedge clk); #1;
      msg_valid = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int mb, ub;
      idle(3); #1;
      rst_n = 1;
      @(negedge clk);
      check("R1 msi_valid after reset", msi_valid, 0);
      check("R1 up_valid after reset", up_valid, 0);

      phase = "R2"; mb = msi_n;
      send(0, 0, 1); idle(6);
      check("R2 msi count", msi_n - mb, 1);
      check("R2 msi pin", msi_log[mb], 0);

      phase = "R3"; mb = msi_n; ub = up_n;
      send(0, 1, 1); send(0, 0, 1); send(0, 0, 0); idle(4);
      check("R3 no extra msi while held", msi_n - mb, 0);
      send(0, 1, 0); idle(3);
      send(0, 2, 1); idle(6);
      check("R3 msi after full release", msi_n - mb, 1);
      check("R3 no upstream for unmasked", up_n - ub, 0);
      send(0, 2, 0);

      phase = "R4"; @(posedge clk); #1; cfg_pin_mask = 4'b0010;
      mb = msi_n; ub = up_n;
      send(1, 2, 1); idle(3);
      check("R4 upstream assert count", up_n - ub, 1);
      check("R4 upstream assert code", up_log[ub], 'b101);
      send(1, 2, 0); idle(3);
      check("R4 upstream deassert code", up_log[ub + 1], 'b001);
      check("R4 no msi for masked", msi_n - mb, 0);

      phase = "R10"; ub = up_n; mb = msi_n;
      send(1, 3, 1); send(0, 3, 1); idle(6);
      check("R10 out-of-range source upstream", up_n - ub, 0);
      check("R10 out-of-range source msi", msi_n - mb, 0);

      phase = "R5"; @(posedge clk); #1; cfg_boot_dis = 1;
      ub = up_n; mb = msi_n;
      send(1, 0, 1); send(2, 0, 1); idle(6);
      check("R5 masked pin silent", up_n - ub, 0);
      check("R5 unmasked msi", msi_n - mb, 1);
      check("R5 unmasked msi pin", msi_log[mb], 2);
      send(1, 0, 0); send(2, 0, 0); idle(2);
      @(posedge clk); #1; cfg_boot_dis = 0;

      phase = "R6"; @(posedge clk); #1; cfg_route_dis = 1;
      ub = up_n; mb = msi_n;
      send(1, 1, 1); send(3, 1, 1); idle(6);
      check("R6 masked pin no action", up_n - ub, 0);
      check("R6 unmasked msi pin", (msi_n - mb == 1) ? msi_log[mb] : -1, 3);
      send(1, 1, 0); send(3, 1, 0); idle(2);
      @(posedge clk); #1; cfg_route_dis = 0;

      phase = "R7"; @(posedge clk); #1; cfg_pin_mask = 4'b0110;
      send(2, 1, 1); idle(3);
      ub = up_n; mb = msi_n;
      @(posedge clk); #1; cfg_pin_mask = 4'b0010; idle(6);
      check("R7 withdraw on unmask", (up_n - ub == 1) ? up_log[ub] : -1, 'b010);
      check("R7 msi after unmask", (msi_n - mb == 1) ? msi_log[mb] : -1, 2);
      ub = up_n;
      @(posedge clk); #1; cfg_pin_mask = 4'b0110; idle(3);
      check("R7 forward again when masked", (up_n - ub == 1) ? up_log[ub] : -1, 'b110);
      @(posedge clk); #1; cfg_boot_dis = 1; idle(3);
      check("R7 withdraw on boot disable", (up_n - ub == 2) ? up_log[ub + 1] : -1, 'b010);
      send(2, 1, 0); idle(2);
      @(posedge clk); #1; cfg_boot_dis = 0; cfg_pin_mask = 4'b1110;

      phase = "R8"; @(posedge clk); #1; cfg_boot_dis = 1;
      send(3, 0, 1); send(2, 0, 1); send(1, 0, 1); idle(2);
      ub = up_n;
      @(posedge clk); #1; cfg_boot_dis = 0; idle(5);
      check("R8 message count", up_n - ub, 3);
      check("R8 first", up_log[ub], 'b101);
      check("R8 second", up_log[ub + 1], 'b110);
      check("R8 third", up_log[ub + 2], 'b111);
      send(1, 0, 0); send(2, 0, 0); send(3, 0, 0); idle(4);
      @(posedge clk); #1; cfg_pin_mask = 4'b0000;

      phase = "R9"; @(posedge clk); #1; msi_ready = 0;
      mb = msi_n;
      for (int k = 0; k < 5; k++) begin send(0, 0, 1); send(0, 0, 0); end
      send(3, 0, 1); send(3, 0, 0); idle(4);
      @(negedge clk);
      check("R9 held while stalled valid", msi_valid, 1);
      check("R9 held while stalled pin", msi_pin, 0);
      check("R9 nothing granted while stalled", msi_n - mb, 0);
      @(posedge clk); #1; msi_ready = 1; idle(10);
      check("R9 grant count with saturation", msi_n - mb, 5);
      check("R9 order 1", msi_log[mb + 3], 0);
      check("R9 order last", msi_log[mb + 4], 3);

      summary();
      $finish;
   end
endmodule